// File: doc/BRIEF.md
# Burst-of-Four Wrap-Order Data Steering

This block steers data for a double-data-rate memory whose array is four times wider than its external data bus. A write is gathered beat by beat into a wide staging word. The staging word is handed to the array only after the fourth beat has arrived, and the array then takes the whole word in one update. A read takes one wide word from the array in a single access. After a fixed latency, the block sends that word out as four narrow beats. The two data beats of each external clock are modelled here as one beat per cycle on a single-rate internal clock, and a beat index reports which slice of the wide word is on the bus.

A parameter selects one of two port styles. In the wide-port style, the two low address bits of each command set the slice the burst starts on (the needed word comes first), and the order then wraps modulo four. In the narrow-port style those two bits are not part of the address port, and every burst runs slice 0, 1, 2, 3. A per-beat lane-enable mask travels with the write data, so that lanes left disabled keep their previous contents. The array is a plain behavioural register file. A read that arrives while a completed write is still waiting to enter the array returns the new data.

Top module: `quad_beat_mux`

## Requirements
- R1: After reset, `rd_valid` is low and every row of the array reads back as all zeros.
- R2: A write accepted in cycle T takes its beats in cycles T..T+3, with the first beat presented together with the command. A read accepted in cycle T+3 returns the complete old word, with none of the new beats in it.
- R3: The wide word of a row is made of four slices, and slice s is bits [s*BEAT_W +: BEAT_W]. Beat k of a read accepted in cycle T is on `rd_data` in cycle T+RD_LAT+k, with `rd_valid` high and `rd_beat` equal to the slice index.
- R4: Each accepted read gives exactly four beats with `rd_valid` high. Reads accepted every fourth cycle give an unbroken stream of beats.
- R5: In wide-port mode the address is {row, start}, with start in bits [1:0]. Both read and write bursts visit slices start, start+1, ... modulo 4.
- R6: In narrow-port mode the address is the row alone. Every burst visits slices 0, 1, 2, 3 in that order.
- R7: Bit i of `wr_mask` enables lane i, which is bits [i*LANE_W +: LANE_W] of the beat it arrives with. A lane whose bit is 0 keeps its previous array contents.
- R8: A read accepted in cycle T+4, while the completed write is still waiting and before it enters the array, returns the new data.
- R9: `wr_cmd` is ignored during cycles T+1..T+3 of a write burst; the data bus is still taken as beats of that burst. `rd_cmd` is ignored in the three cycles after an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, one beat per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_cmd | input | 1 | Starts a write burst; its first beat is on `wr_data` in the same cycle |
| wr_addr | input | ROW_W+2*WIDE_PORT | Write row, plus the start slice in the wide-port style |
| wr_data | input | BEAT_W | Write beat |
| wr_mask | input | BEAT_W/LANE_W | Lane enables for the current write beat |
| rd_cmd | input | 1 | Starts a read burst |
| rd_addr | input | ROW_W+2*WIDE_PORT | Read row, plus the start slice in the wide-port style |
| rd_valid | output | 1 | A read beat is on `rd_data` |
| rd_beat | output | 2 | Slice index of the current read beat |
| rd_data | output | BEAT_W | Read beat |

## Verification
The hardest situation to set up is a read that lands exactly on the boundary of a write burst. If the read arrives with the last write beat, it must return the full old word. If it arrives one cycle later, while the completed word is waiting for the array, it must return the new word. The bench's write task can therefore place a read on the final beat cycle, and the read that follows the task lands on the waiting cycle. Every row is swept with every write start and every read start, so each wrap order is exercised against arithmetically computed slices.

// File: rtl/qbm_pkg.sv
package qbm_pkg;

    // Beats per internal access
    localparam int unsigned BURST_LEN = 4;
    localparam int unsigned PTR_W     = 2;

    typedef logic [PTR_W-1:0] beat_ptr_t;

    // Linear modulo-four advance of a beat pointer
    function automatic beat_ptr_t ptr_step(input beat_ptr_t p);
        return p + beat_ptr_t'(1);
    endfunction

endpackage

// File: rtl/qbm_wr_collect.sv
module qbm_wr_collect
    import qbm_pkg::*;
#(
    parameter int unsigned BEAT_W = 8,
    parameter int unsigned LANE_W = 4,
    parameter int unsigned ROW_W  = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cmd_i,
    input  logic [ROW_W-1:0]                   row_i,
    input  beat_ptr_t                          seed_i,
    input  logic [BEAT_W-1:0]                  data_i,
    input  logic [BEAT_W/LANE_W-1:0]           mask_i,
    output logic                               commit_v_o,
    output logic [ROW_W-1:0]                   commit_row_o,
    output logic [BEAT_W*BURST_LEN-1:0]        commit_word_o,
    output logic [BEAT_W/LANE_W*BURST_LEN-1:0] commit_en_o
);
    localparam int unsigned LANES  = BEAT_W / LANE_W;
    localparam int unsigned WORD_W = BEAT_W * BURST_LEN;
    localparam int unsigned WEN_W  = LANES * BURST_LEN;

    logic              busy;
    beat_ptr_t         ptr;
    logic [1:0]        left;
    logic [ROW_W-1:0]  row_q;
    logic [WORD_W-1:0] word_q, word_nx;
    logic [WEN_W-1:0]  en_q, en_nx;
    logic              acc, take, fin;
    beat_ptr_t         cur_ptr;

    assign acc     = cmd_i && !busy;
    assign take    = acc || busy;
    assign fin     = busy && (left == 2'd0);
    assign cur_ptr = acc ? seed_i : ptr;

    // Drop the current beat and its lane enables into its slice
    always_comb begin
        word_nx = word_q;
        en_nx   = acc ? '0 : en_q;
        word_nx[cur_ptr*BEAT_W +: BEAT_W] = data_i;
        en_nx[cur_ptr*LANES +: LANES]     = mask_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy          <= 1'b0;
            ptr           <= '0;
            left          <= '0;
            row_q         <= '0;
            word_q        <= '0;
            en_q          <= '0;
            commit_v_o    <= 1'b0;
            commit_row_o  <= '0;
            commit_word_o <= '0;
            commit_en_o   <= '0;
        end else begin
            commit_v_o <= fin;
            if (fin) begin
                commit_row_o  <= row_q;
                commit_word_o <= word_nx;
                commit_en_o   <= en_nx;
            end
            if (take) begin
                word_q <= word_nx;
                en_q   <= en_nx;
            end
            if (acc) begin
                busy  <= 1'b1;
                ptr   <= ptr_step(seed_i);
                left  <= 2'd2;
                row_q <= row_i;
            end else if (busy) begin
                ptr <= ptr_step(ptr);
                if (left == 2'd0) busy <= 1'b0;
                else              left <= left - 2'd1;
            end
        end
    end

    // R2
    commit_after_four_chk: assert property (@(posedge clk) disable iff (rst)
        acc |-> ##4 commit_v_o);

endmodule

// File: rtl/qbm_store.sv
module qbm_store
    import qbm_pkg::*;
#(
    parameter int unsigned BEAT_W = 8,
    parameter int unsigned LANE_W = 4,
    parameter int unsigned ROW_W  = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               commit_v_i,
    input  logic [ROW_W-1:0]                   commit_row_i,
    input  logic [BEAT_W*BURST_LEN-1:0]        commit_word_i,
    input  logic [BEAT_W/LANE_W*BURST_LEN-1:0] commit_en_i,
    input  logic [ROW_W-1:0]                   rd_row_i,
    output logic [BEAT_W*BURST_LEN-1:0]        rd_word_o
);
    localparam int unsigned ROWS   = 1 << ROW_W;
    localparam int unsigned WORD_W = BEAT_W * BURST_LEN;
    localparam int unsigned WEN_W  = BEAT_W / LANE_W * BURST_LEN;

    logic [WORD_W-1:0] mem [ROWS];
    logic [WORD_W-1:0] old_wr, old_rd, new_wr;
    logic              fwd;

    assign old_wr = mem[commit_row_i];
    assign old_rd = mem[rd_row_i];
    assign fwd    = commit_v_i && (commit_row_i == rd_row_i);

    // Lane merge for the array update and for the coherent read view
    generate
        for (genvar l = 0; l < WEN_W; l++) begin : g_lane
            assign new_wr[l*LANE_W +: LANE_W] = commit_en_i[l]
                ? commit_word_i[l*LANE_W +: LANE_W] : old_wr[l*LANE_W +: LANE_W];
            assign rd_word_o[l*LANE_W +: LANE_W] = (fwd && commit_en_i[l])
                ? commit_word_i[l*LANE_W +: LANE_W] : old_rd[l*LANE_W +: LANE_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ROWS; i++) mem[i] <= '0;
        end else if (commit_v_i) begin
            mem[commit_row_i] <= new_wr;
        end
    end

endmodule

// File: rtl/qbm_rd_serial.sv
module qbm_rd_serial
    import qbm_pkg::*;
#(
    parameter int unsigned BEAT_W    = 8,
    parameter int unsigned RD_LAT    = 2,
    parameter int unsigned WIDE_PORT = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_i,
    input  beat_ptr_t                   seed_i,
    input  logic [BEAT_W*BURST_LEN-1:0] word_i,
    output logic                        valid_o,
    output beat_ptr_t                   beat_o,
    output logic [BEAT_W-1:0]           data_o
);
    localparam int unsigned WORD_W = BEAT_W * BURST_LEN;

    typedef struct packed {
        logic              v;
        beat_ptr_t         seed;
        logic [WORD_W-1:0] word;
    } rd_stage_t;

    logic       [1:0]  gap;
    logic              acc;
    rd_stage_t         stg_in, stg_out;
    logic              act;
    beat_ptr_t         ptr;
    logic [1:0]        left;
    logic [WORD_W-1:0] word_q;

    assign acc    = cmd_i && (gap == 2'd0);
    assign stg_in = '{v: acc, seed: seed_i, word: word_i};

    always_ff @(posedge clk) begin
        if (rst)             gap <= '0;
        else if (acc)        gap <= 2'd3;
        else if (gap != 2'd0) gap <= gap - 2'd1;
    end

    // Latency padding in front of the serialiser
    generate
        if (RD_LAT <= 1) begin : g_nodly
            assign stg_out = stg_in;
        end else begin : g_dly
            rd_stage_t pipe [RD_LAT-1];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < RD_LAT-1; i++) pipe[i] <= '0;
                end else begin
                    pipe[0] <= stg_in;
                    for (int i = 1; i < RD_LAT-1; i++) pipe[i] <= pipe[i-1];
                end
            end
            assign stg_out = pipe[RD_LAT-2];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= 1'b0;
            ptr    <= '0;
            left   <= '0;
            word_q <= '0;
        end else if (stg_out.v) begin
            act    <= 1'b1;
            ptr    <= stg_out.seed;
            left   <= 2'd3;
            word_q <= stg_out.word;
        end else if (act) begin
            if (left == 2'd0) begin
                act <= 1'b0;
            end else begin
                left <= left - 2'd1;
                ptr  <= ptr_step(ptr);
            end
        end
    end

    assign valid_o = act;
    assign beat_o  = ptr;
    assign data_o  = word_q[ptr*BEAT_W +: BEAT_W];

    // R5
    wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (act && left != 2'd0 && !stg_out.v) |=> (ptr == ptr_step($past(ptr))));

    generate
        if (WIDE_PORT == 0) begin : g_narrow_chk
            // R6
            narrow_start_chk: assert property (@(posedge clk) disable iff (rst)
                stg_out.v |=> (ptr == '0));
        end
    endgenerate

endmodule

// File: rtl/quad_beat_mux.sv
module quad_beat_mux
    import qbm_pkg::*;
#(
    parameter int unsigned BEAT_W    = 8,
    parameter int unsigned LANE_W    = 4,
    parameter int unsigned ROW_W     = 3,
    parameter int unsigned RD_LAT    = 2,
    parameter int unsigned WIDE_PORT = 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_cmd,
    input  logic [ROW_W+2*WIDE_PORT-1:0]    wr_addr,
    input  logic [BEAT_W-1:0]               wr_data,
    input  logic [BEAT_W/LANE_W-1:0]        wr_mask,
    input  logic                            rd_cmd,
    input  logic [ROW_W+2*WIDE_PORT-1:0]    rd_addr,
    output logic                            rd_valid,
    output logic [1:0]                      rd_beat,
    output logic [BEAT_W-1:0]               rd_data
);
    localparam int unsigned LANES  = BEAT_W / LANE_W;
    localparam int unsigned WORD_W = BEAT_W * BURST_LEN;
    localparam int unsigned WEN_W  = LANES * BURST_LEN;
    localparam int unsigned AW     = ROW_W + 2 * WIDE_PORT;

    logic [ROW_W-1:0]  wr_row, rd_row, c_row;
    beat_ptr_t         wr_seed, rd_seed, beat_ptr;
    logic              c_v;
    logic [WORD_W-1:0] c_word, rd_view;
    logic [WEN_W-1:0]  c_en;

    // Port style picks how the starting slice is derived
    generate
        if (WIDE_PORT != 0) begin : g_wide
            assign wr_row  = wr_addr[AW-1:2];
            assign wr_seed = wr_addr[1:0];
            assign rd_row  = rd_addr[AW-1:2];
            assign rd_seed = rd_addr[1:0];
        end else begin : g_narrow
            assign wr_row  = wr_addr;
            assign wr_seed = '0;
            assign rd_row  = rd_addr;
            assign rd_seed = '0;
        end
    endgenerate

    qbm_wr_collect #(.BEAT_W(BEAT_W), .LANE_W(LANE_W), .ROW_W(ROW_W)) i_collect (
        .clk(clk), .rst(rst), .cmd_i(wr_cmd), .row_i(wr_row), .seed_i(wr_seed),
        .data_i(wr_data), .mask_i(wr_mask), .commit_v_o(c_v), .commit_row_o(c_row),
        .commit_word_o(c_word), .commit_en_o(c_en)
    );

    qbm_store #(.BEAT_W(BEAT_W), .LANE_W(LANE_W), .ROW_W(ROW_W)) i_store (
        .clk(clk), .rst(rst), .commit_v_i(c_v), .commit_row_i(c_row),
        .commit_word_i(c_word), .commit_en_i(c_en), .rd_row_i(rd_row),
        .rd_word_o(rd_view)
    );

    qbm_rd_serial #(.BEAT_W(BEAT_W), .RD_LAT(RD_LAT), .WIDE_PORT(WIDE_PORT)) i_serial (
        .clk(clk), .rst(rst), .cmd_i(rd_cmd), .seed_i(rd_seed), .word_i(rd_view),
        .valid_o(rd_valid), .beat_o(beat_ptr), .data_o(rd_data)
    );

    assign rd_beat = beat_ptr;

    // R4
    four_beats_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |=> rd_valid ##1 rd_valid ##1 rd_valid);

endmodule

// File: tb/test_quad_beat_mux.sv
`timescale 1ns/1ps
module test_quad_beat_mux;
    localparam int RD_LAT = 2;
    localparam int NMAX   = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    // Wide-port instance
    logic       w_wr_cmd = 0, w_rd_cmd = 0;
    logic [4:0] w_wr_addr = 0, w_rd_addr = 0;
    logic [7:0] w_wr_data = 0;
    logic [1:0] w_wr_mask = 0;
    logic       w_rd_valid;
    logic [1:0] w_rd_beat;
    logic [7:0] w_rd_data;

    // Narrow-port instance
    logic       n_wr_cmd = 0, n_rd_cmd = 0;
    logic [2:0] n_wr_addr = 0, n_rd_addr = 0;
    logic [7:0] n_wr_data = 0;
    logic [1:0] n_wr_mask = 0;
    logic       n_rd_valid;
    logic [1:0] n_rd_beat;
    logic [7:0] n_rd_data;

    quad_beat_mux #(.BEAT_W(8), .LANE_W(4), .ROW_W(3), .RD_LAT(RD_LAT), .WIDE_PORT(1)) i_quad_beat_mux (
        .clk(clk), .rst(rst), .wr_cmd(w_wr_cmd), .wr_addr(w_wr_addr), .wr_data(w_wr_data),
        .wr_mask(w_wr_mask), .rd_cmd(w_rd_cmd), .rd_addr(w_rd_addr),
        .rd_valid(w_rd_valid), .rd_beat(w_rd_beat), .rd_data(w_rd_data));

    quad_beat_mux #(.BEAT_W(8), .LANE_W(4), .ROW_W(3), .RD_LAT(RD_LAT), .WIDE_PORT(0)) i_quad_beat_mux_n (
        .clk(clk), .rst(rst), .wr_cmd(n_wr_cmd), .wr_addr(n_wr_addr), .wr_data(n_wr_data),
        .wr_mask(n_wr_mask), .rd_cmd(n_rd_cmd), .rd_addr(n_rd_addr),
        .rd_valid(n_rd_valid), .rd_beat(n_rd_beat), .rd_data(n_rd_data));

    int tests = 0, fails = 0, cyc = 0;
    logic [31:0] mw [8];
    logic [31:0] mn [8];

    int         ne = 0, ng = 0, chk = 0;
    logic [7:0] exp_d [NMAX];
    logic [1:0] exp_b [NMAX];
    int         exp_c [NMAX];
    string      exp_r [NMAX];
    logic [7:0] got_d [NMAX];
    logic [1:0] got_b [NMAX];
    int         got_c [NMAX];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && w_rd_valid && ng < NMAX) begin
            got_d[ng] = w_rd_data;
            got_b[ng] = w_rd_beat;
            got_c[ng] = cyc;
            ng++;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] pat(input int row, input int tag);
        return 32'h9E3779B1 * (row * 64 + tag + 1) + 32'h01234567;
    endfunction

    task automatic push_read(input int row, input int start, input string req);
        for (int k = 0; k < 4; k++) begin
            int s = (start + k) % 4;
            exp_d[ne] = mw[row][s*8 +: 8];
            exp_b[ne] = 2'(s);
            exp_c[ne] = cyc + RD_LAT + k;
            exp_r[ne] = req;
            ne++;
        end
    endtask

    // Four-cycle read slot on the wide instance
    task automatic w_read(input int row, input int start, input string req);
        w_rd_cmd  = 1'b1;
        w_rd_addr = 5'(row * 4 + start);
        push_read(row, start, req);
        tick();
        w_rd_cmd = 1'b0;
        repeat (3) tick();
    endtask

    // Write burst on the wide instance; en holds two lane bits per slice
    task automatic w_write(input int row, input int start, input logic [31:0] word,
                           input logic [7:0] en, input int rd_last, input int poke_row);
        for (int k = 0; k < 4; k++) begin
            int s = (start + k) % 4;
            w_wr_cmd  = (k == 0);
            if (k == 0) w_wr_addr = 5'(row * 4 + start);
            w_wr_data = word[s*8 +: 8];
            w_wr_mask = en[s*2 +: 2];
            if (k == 1 && poke_row >= 0) begin
                w_wr_cmd  = 1'b1;
                w_wr_addr = 5'(poke_row * 4);
            end
            if (k == 3 && rd_last >= 0) begin
                w_rd_cmd  = 1'b1;
                w_rd_addr = 5'(row * 4 + rd_last);
                push_read(row, rd_last, "R2");
            end
            tick();
            w_rd_cmd = 1'b0;
        end
        w_wr_cmd = 1'b0;
        for (int l = 0; l < 8; l++)
            if (en[l]) mw[row][l*4 +: 4] = word[l*4 +: 4];
    endtask

    task automatic drain(input string req);
        repeat (RD_LAT + 6) tick();
        check(req, "beat count", ng, ne);
        for (int i = chk; i < ne && i < ng; i++) begin
            check(exp_r[i], "beat data", got_d[i], exp_d[i]);
            check(exp_r[i], "beat index", got_b[i], exp_b[i]);
            check("R3", "beat cycle", got_c[i], exp_c[i]);
        end
        if (ng > ne) ne = ng;
        else ng = ne;
        chk = ne;
    endtask

    task automatic n_write(input int row, input logic [31:0] word, input logic [7:0] en);
        for (int k = 0; k < 4; k++) begin
            n_wr_cmd  = (k == 0);
            n_wr_addr = 3'(row);
            n_wr_data = word[k*8 +: 8];
            n_wr_mask = en[k*2 +: 2];
            tick();
        end
        n_wr_cmd = 1'b0;
        for (int l = 0; l < 8; l++)
            if (en[l]) mn[row][l*4 +: 4] = word[l*4 +: 4];
    endtask

    task automatic n_read(input int row);
        n_rd_cmd  = 1'b1;
        n_rd_addr = 3'(row);
        tick();
        n_rd_cmd = 1'b0;
        repeat (RD_LAT - 1) tick();
        for (int k = 0; k < 4; k++) begin
            check("R6", "narrow valid", n_rd_valid, 1);
            check("R6", "narrow beat index", n_rd_beat, k);
            check("R6", "narrow data", n_rd_data, mn[row][k*8 +: 8]);
            tick();
        end
        check("R6", "narrow valid after burst", n_rd_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++) begin
            mw[r] = '0;
            mn[r] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();

        // R1: reset state
        check("R1", "wide rd_valid after reset", w_rd_valid, 0);
        check("R1", "narrow rd_valid after reset", n_rd_valid, 0);
        for (int r = 0; r < 8; r++) w_read(r, r % 4, "R1");
        drain("R1");
        n_read(5);

        // R3 R5 R8: every row, every write start, every read start
        for (int r = 0; r < 8; r++)
            for (int ws = 0; ws < 4; ws++) begin
                w_write(r, ws, pat(r, ws), 8'hFF, -1, -1);
                for (int rs = 0; rs < 4; rs++) w_read(r, (ws + rs) % 4, "R5");
            end
        drain("R5");

        // R4: back-to-back read slots give a continuous stream
        for (int r = 0; r < 8; r++) w_read(r, (r + 1) % 4, "R4");
        drain("R4");

        // R7: lane enables keep disabled lanes
        w_write(5, 0, pat(5, 40), 8'hFF, -1, -1);
        w_write(5, 1, pat(5, 41), 8'hA5, -1, -1);
        w_read(5, 0, "R7");
        w_write(5, 2, pat(5, 42), 8'h3C, -1, -1);
        w_read(5, 3, "R7");
        w_write(5, 3, pat(5, 43), 8'h00, -1, -1);
        w_read(5, 1, "R7");
        w_write(5, 0, pat(5, 44), 8'hC3, -1, -1);
        w_read(5, 2, "R7");
        drain("R7");

        // R2: read on the final write beat sees the whole old word
        w_write(6, 1, pat(6, 50), 8'hFF, 2, -1);
        repeat (3) tick();
        w_read(6, 0, "R2");
        drain("R2");

        // R8: read in the cycle right after the last beat sees new data
        w_write(7, 3, pat(7, 60), 8'hFF, -1, -1);
        w_read(7, 1, "R8");
        w_write(7, 2, pat(7, 61), 8'h5A, -1, -1);
        w_read(7, 0, "R8");
        drain("R8");

        // R9: extra write command mid-burst is ignored
        w_write(3, 1, pat(3, 70), 8'hFF, -1, 4);
        w_read(3, 1, "R9");
        w_read(4, 0, "R9");
        // R9: second read command inside the blocking window is ignored
        w_rd_cmd  = 1'b1;
        w_rd_addr = 5'(2 * 4);
        push_read(2, 0, "R9");
        tick();
        w_rd_addr = 5'(4 * 4 + 3);
        tick();
        w_rd_cmd = 1'b0;
        repeat (2) tick();
        drain("R9");

        // R6 R7: narrow-port instance, fixed order and lane enables
        for (int r = 0; r < 8; r++) begin
            n_write(r, pat(r, 80), 8'hFF);
            n_read(r);
        end
        n_write(2, pat(2, 81), 8'h96);
        n_read(2);
        n_write(2, pat(2, 82), 8'h00);
        n_read(2);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule